// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory Word Guard

This block sits between a requester and a word-wide memory array. A write is widened with check bits into a protected codeword before it reaches the array. A read is checked on the way back. One flipped bit anywhere in the codeword is repaired, and the repaired data is returned. Two flipped bits are flagged as uncorrectable, and the data is withheld. After a repair, the clean codeword is written back to the same location. That memory slot costs the requester one stalled cycle.

Software sees two level outputs. One is an interrupt request for repaired errors. The other is a separate fatal-error line. Behind them are sticky status fields: the address and syndrome of the first error, and a saturating count of repairs. The fields are cleared by write-one pulses. For test, a mask can be armed that flips chosen codeword bits on the next requester write only. Both single-bit and double-bit faults can then be planted at will.

The memory is a simple synchronous array with one registered read port. A read accepted at one clock edge responds in the cycle that follows.

Top module: `secded_mem_guard`

## Requirements
- R1: The codeword is 72 bits and has the following layout.
  - Bit 0 is the overall parity bit.
  - Bits 1, 2, 4, 8, 16, 32 and 64 are positional check bits.
  - The 64 data bits fill the remaining positions in ascending order.
  - A flip of codeword bit k (k ≥ 1) gives the syndrome k. A flip of bit 0 gives syndrome 0. Flips of bits i and j give the syndrome i XOR j.
- R2: A read accepted at a clock edge responds in the following cycle with `rsp_valid` high. A clean read returns the last written data with both error flags low.
- R3: A read whose codeword has exactly one flipped bit, including bit 0, returns the original data with `rsp_corrected` high and `rsp_fatal` low.
- R4: A read whose codeword has exactly two flipped bits raises `rsp_fatal` with `rsp_corrected` low. It returns all-zero data.
- R5: In the response cycle of a corrected read, `req_ready` is low for exactly that cycle. The clean codeword is written back to the same address, so a later read of that address is clean.
- R6: A pulse on `inj_load` arms `inj_mask`. The mask is XORed into the codeword of the next requester write only, and then it disarms.
  - Write-backs never consume the mask.
  - If a load and a write coincide, the write uses the previously armed mask and the new mask stays armed.
- R7: `irq_corr` equals the sticky repaired flag `sts_flags[0]`. That flag sets in the cycle after a corrected response.
- R8: `err_fatal` equals the sticky fatal flag `sts_flags[1]`. That flag sets in the cycle after an uncorrectable response, independently of `irq_corr`.
- R9: `sts_addr` and `sts_syndrome` capture the address and syndrome of an error response only when both sticky flags are clear at that edge. Otherwise they hold.
- R10: `sts_count` counts corrected responses and saturates at its all-ones value.
- R11: `sts_clr` clears state on write-one pulses.
  - Bit 0 clears `sts_flags[0]`, bit 1 clears `sts_flags[1]`, and bit 2 clears `sts_count`.
  - A set or count event in the same cycle takes effect after the clear.
- R12: After reset, `req_ready` is high, no response is pending, all status fields and both error lines are zero, and no injection mask is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Write data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 64 | Read data (repaired, or zero when fatal) |
| rsp_corrected | output | 1 | Response had one repaired bit |
| rsp_fatal | output | 1 | Response is uncorrectable |
| inj_load | input | 1 | Arm the injection mask |
| inj_mask | input | 72 | Codeword bits to flip on the next write |
| sts_clr | input | 3 | Write-one clear pulses |
| sts_flags | output | 2 | Sticky flags: [0] repaired, [1] fatal |
| sts_count | output | CNT_W | Saturating repaired-error count |
| sts_addr | output | ADDR_W | Address of first error |
| sts_syndrome | output | 7 | Syndrome of first error |
| irq_corr | output | 1 | Repaired-error interrupt request |
| err_fatal | output | 1 | Uncorrectable-error line |

## Verification
The hardest situation to reach from the ports is a corrected response that coincides with other traffic. That includes a back-to-back read that must stall behind the write-back, a clear pulse landing in the same cycle as the event it would erase, and a new mask loaded in the cycle that consumes the old one. The stimulus plants exact codeword faults through the injection mask. It then times further reads, clears and mask loads from the driving tasks so that they fall in that response cycle. The reference model tracks each address as data plus a fault mask. Its expectations therefore follow from the fault weight and positions alone, without any encoder.

// File: rtl/secded_pkg.sv
package secded_pkg;
  parameter int DATA_W = 64;

  function automatic int calc_par_w(int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  localparam int PAR_W = calc_par_w(DATA_W);
  localparam int CW_W  = DATA_W + PAR_W + 1;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [PAR_W-1:0]  syn_t;

  function automatic bit is_pow2(int i);
    return (i & (i - 1)) == 0;
  endfunction

  // Scatter data into non-power-of-two slots, then fill positional and overall parity.
  function automatic cw_t encode(data_t d);
    cw_t c;
    int  k;
    c = '0;
    k = 0;
    for (int i = 1; i < CW_W; i++) begin
      if (!is_pow2(i)) begin
        c[i] = d[k];
        k++;
      end
    end
    for (int j = 0; j < PAR_W; j++) begin
      for (int i = 1; i < CW_W; i++) begin
        if (!is_pow2(i) && ((i >> j) & 1) == 1) c[1 << j] ^= c[i];
      end
    end
    c[0] = ^c[CW_W-1:1];
    return c;
  endfunction

  function automatic data_t extract(cw_t c);
    data_t d;
    int    k;
    d = '0;
    k = 0;
    for (int i = 1; i < CW_W; i++) begin
      if (!is_pow2(i)) begin
        d[k] = c[i];
        k++;
      end
    end
    return d;
  endfunction

  // XOR of the indices of every set bit above position 0.
  function automatic syn_t syndrome(cw_t c);
    syn_t s;
    s = '0;
    for (int i = 1; i < CW_W; i++) begin
      if (c[i]) s = s ^ PAR_W'(i);
    end
    return s;
  endfunction
endpackage

// File: rtl/secded_sram.sv
module secded_sram #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   rdata <= '0;
    else if (!we) rdata <= mem[addr];
  end
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
(
  input  cw_t   cw_in,
  output data_t data_fix,
  output syn_t  syn,
  output logic  corr,
  output logic  fatal
);
  logic odd;
  logic in_range;
  cw_t  cw_fix;

  always_comb begin
    syn      = syndrome(cw_in);
    odd      = ^cw_in;
    in_range = 32'(syn) < CW_W;
    corr     = odd && in_range;
    fatal    = (!odd && syn != '0) || (odd && !in_range);
    cw_fix   = cw_in;
    if (corr && syn != '0) cw_fix = cw_in ^ (CW_W'(1) << syn);
    data_fix = extract(cw_fix);
  end
endmodule

// File: rtl/secded_status.sv
module secded_status #(
  parameter int ADDR_W = 6,
  parameter int SYN_W  = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_corr,
  input  logic              ev_fatal,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [SYN_W-1:0]  ev_syn,
  input  logic [2:0]        clr,
  output logic [1:0]        flags,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] first_addr,
  output logic [SYN_W-1:0]  first_syn
);
  logic [CNT_W-1:0] cnt_base;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_base = clr[2] ? '0 : count;
    cnt_nxt  = (ev_corr && cnt_base != '1) ? cnt_base + 1'b1 : cnt_base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags      <= '0;
      count      <= '0;
      first_addr <= '0;
      first_syn  <= '0;
    end else begin
      if ((ev_corr || ev_fatal) && flags == 2'b00) begin
        first_addr <= ev_addr;
        first_syn  <= ev_syn;
      end
      flags[0] <= ev_corr  | (flags[0] & ~clr[0]);
      flags[1] <= ev_fatal | (flags[1] & ~clr[1]);
      count    <= cnt_nxt;
    end
  end
endmodule

// File: rtl/secded_mem_guard.sv
module secded_mem_guard
  import secded_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_corrected,
  output logic              rsp_fatal,
  input  logic              inj_load,
  input  logic [CW_W-1:0]   inj_mask,
  input  logic [2:0]        sts_clr,
  output logic [1:0]        sts_flags,
  output logic [CNT_W-1:0]  sts_count,
  output logic [ADDR_W-1:0] sts_addr,
  output logic [PAR_W-1:0]  sts_syndrome,
  output logic              irq_corr,
  output logic              err_fatal
);
  // Named internal events.
  logic              rd_pend;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              accept;
  logic              wb_go;
  logic              ev_corr;
  logic              ev_fatal;

  logic              inj_armed;
  cw_t               inj_q;

  cw_t               mem_rdata;
  cw_t               mem_wdata;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  data_t             enc_in;

  data_t             dec_data;
  syn_t              dec_syn;
  logic              dec_corr;
  logic              dec_fatal;

  secded_decoder u_dec (
    .cw_in    (mem_rdata),
    .data_fix (dec_data),
    .syn      (dec_syn),
    .corr     (dec_corr),
    .fatal    (dec_fatal)
  );

  assign ev_corr   = rd_pend & dec_corr;
  assign ev_fatal  = rd_pend & dec_fatal;
  assign wb_go     = ev_corr;
  assign req_ready = ~wb_go;
  assign accept    = req_valid & req_ready;

  always_comb begin
    enc_in    = wb_go ? dec_data : req_wdata;
    mem_wdata = encode(enc_in) ^ ((!wb_go && inj_armed) ? inj_q : '0);
    mem_we    = wb_go | (accept & req_write);
    mem_addr  = wb_go ? rd_addr_q : req_addr;
  end

  secded_sram #(
    .ADDR_W (ADDR_W),
    .WORD_W (CW_W)
  ) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_pend   <= accept & ~req_write;
      rd_addr_q <= req_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inj_armed <= 1'b0;
      inj_q     <= '0;
    end else if (inj_load) begin
      inj_armed <= 1'b1;
      inj_q     <= inj_mask;
    end else if (accept && req_write) begin
      inj_armed <= 1'b0;
      inj_q     <= '0;
    end
  end

  assign rsp_valid     = rd_pend;
  assign rsp_corrected = ev_corr;
  assign rsp_fatal     = ev_fatal;
  assign rsp_rdata     = (rd_pend && !dec_fatal) ? dec_data : '0;

  secded_status #(
    .ADDR_W (ADDR_W),
    .SYN_W  (PAR_W),
    .CNT_W  (CNT_W)
  ) u_sts (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_corr    (ev_corr),
    .ev_fatal   (ev_fatal),
    .ev_addr    (rd_addr_q),
    .ev_syn     (dec_syn),
    .clr        (sts_clr),
    .flags      (sts_flags),
    .count      (sts_count),
    .first_addr (sts_addr),
    .first_syn  (sts_syndrome)
  );

  assign irq_corr  = sts_flags[0];
  assign err_fatal = sts_flags[1];
endmodule

// File: rtl/secded_guard_chk.sv
module secded_guard_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_corrected,
  input logic              rsp_fatal,
  input logic              irq_corr,
  input logic              err_fatal,
  input logic [2:0]        sts_clr,
  input logic [CNT_W-1:0]  sts_count,
  input logic              wb_go
);
  // R5
  stall_only_on_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> rsp_valid && rsp_corrected);

  // R5
  stall_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);

  // R5
  wb_no_read_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_go |=> !rsp_valid);

  // R3
  corr_fatal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_corrected && rsp_fatal));

  // R4
  fatal_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fatal |-> rsp_rdata == '0);

  // R7
  irq_after_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_corrected |=> irq_corr);

  // R8
  fatal_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fatal |=> err_fatal);

  // R10
  count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_clr[2] |=> sts_count >= $past(sts_count));
endmodule

bind secded_mem_guard secded_guard_chk #(
  .DATA_W (secded_pkg::DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_rdata     (rsp_rdata),
  .rsp_corrected (rsp_corrected),
  .rsp_fatal     (rsp_fatal),
  .irq_corr      (irq_corr),
  .err_fatal     (err_fatal),
  .sts_clr       (sts_clr),
  .sts_count     (sts_count),
  .wb_go         (wb_go)
);

// File: tb/secded_mem_guard_tb.sv
module secded_mem_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int CW = 4;
  localparam int DW = 64;
  localparam int KW = 72;
  localparam int SW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_corrected, rsp_fatal;
  logic [DW-1:0] rsp_rdata;
  logic          inj_load = 1'b0;
  logic [KW-1:0] inj_mask = '0;
  logic [2:0]    sts_clr = '0;
  logic [1:0]    sts_flags;
  logic [CW-1:0] sts_count;
  logic [AW-1:0] sts_addr;
  logic [SW-1:0] sts_syndrome;
  logic          irq_corr, err_fatal;

  always #(CLK_PERIOD/2) clk = ~clk;

  secded_mem_guard #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_corrected(rsp_corrected),
    .rsp_fatal(rsp_fatal), .inj_load(inj_load), .inj_mask(inj_mask),
    .sts_clr(sts_clr), .sts_flags(sts_flags), .sts_count(sts_count),
    .sts_addr(sts_addr), .sts_syndrome(sts_syndrome), .irq_corr(irq_corr),
    .err_fatal(err_fatal)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Reference model: each address holds intended data plus a codeword fault mask.
  logic [DW-1:0] m_data [1 << AW];
  logic [KW-1:0] m_err  [1 << AW];
  bit            pend = 0;
  int            pend_addr = 0;
  bit            armed = 0;
  logic [KW-1:0] arm_mask = '0;
  logic [1:0]    flags = '0;
  int            cnt = 0;
  int            f_addr = 0;
  int            f_syn = 0;

  function automatic int fault_syn(logic [KW-1:0] m);
    int s = 0;
    for (int i = 1; i < KW; i++) if (m[i]) s = s ^ i;
    return s;
  endfunction

  function automatic int pend_weight();
    return pend ? $countones(m_err[pend_addr]) : 0;
  endfunction

  task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial for (int a = 0; a < (1 << AW); a++) begin m_data[a] = '0; m_err[a] = '0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      pend = 0; armed = 0; arm_mask = '0; flags = '0; cnt = 0; f_addr = 0; f_syn = 0;
    end else begin
      int  w;
      bit  ec, ef, rdy;
      w  = pend_weight();
      ec = pend && w == 1;
      ef = pend && w >= 2;
      rdy = !ec;
      if ((ec || ef) && flags == 2'b00) begin
        f_addr = pend_addr;
        f_syn  = fault_syn(m_err[pend_addr]);
      end
      if (sts_clr[2]) cnt = 0;
      if (ec && cnt < (1 << CW) - 1) cnt++;
      flags[0] = ec | (flags[0] & ~sts_clr[0]);
      flags[1] = ef | (flags[1] & ~sts_clr[1]);
      if (ec) m_err[pend_addr] = '0;
      pend = 0;
      if (req_valid && rdy) begin
        if (req_write) begin
          m_data[req_addr] = req_wdata;
          m_err[req_addr]  = armed ? arm_mask : '0;
          if (!inj_load) begin armed = 0; arm_mask = '0; end
        end else begin
          pend = 1;
          pend_addr = int'(req_addr);
        end
      end
      if (inj_load) begin armed = 1; arm_mask = inj_mask; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int w;
      w = pend_weight();
      cmp("R5", "req_ready", 64'(req_ready), 64'(!(pend && w == 1)));
      cmp("R2", "rsp_valid", 64'(rsp_valid), 64'(pend));
      cmp("R3 R6", "rsp_corrected", 64'(rsp_corrected), 64'(pend && w == 1));
      cmp("R4", "rsp_fatal", 64'(rsp_fatal), 64'(pend && w >= 2));
      if (pend) cmp(w >= 2 ? "R4" : "R2 R3", "rsp_rdata", rsp_rdata,
                    w >= 2 ? 64'd0 : m_data[pend_addr]);
      cmp("R7", "irq_corr", 64'(irq_corr), 64'(flags[0]));
      cmp("R8", "err_fatal", 64'(err_fatal), 64'(flags[1]));
      cmp("R11", "sts_flags", 64'(sts_flags), 64'(flags));
      cmp("R10", "sts_count", 64'(sts_count), 64'(cnt));
      cmp("R9", "sts_addr", 64'(sts_addr), 64'(f_addr));
      cmp("R1", "sts_syndrome", 64'(sts_syndrome), 64'(f_syn));
    end
  end

  task automatic op(bit wr, int a, logic [DW-1:0] d);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk); #1;
    req_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic load_inj(logic [KW-1:0] m);
    @(negedge clk); #1;
    req_valid = 1'b0; inj_load = 1'b1; inj_mask = m;
    @(negedge clk); #1;
    inj_load = 1'b0;
  endtask

  task automatic clear(logic [2:0] b);
    @(negedge clk); #1;
    req_valid = 1'b0; sts_clr = b;
    @(negedge clk); #1;
    sts_clr = '0;
  endtask

  task automatic single_fault(int a, int pos);
    load_inj(KW'(1) << pos);
    op(1, a, {$urandom, $urandom});
    op(0, a, '0);
    op(0, a, '0);
    idle(1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int pos_list [12] = '{0, 1, 2, 3, 4, 8, 16, 32, 64, 71, 37, 50};
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    cmp("R12", "reset req_ready", 64'(req_ready), 64'd1);
    cmp("R12", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    cmp("R12", "reset flags", 64'({sts_flags, irq_corr, err_fatal}), 64'd0);
    cmp("R12", "reset count", 64'(sts_count), 64'd0);
    cmp("R12", "reset addr/syn", 64'({sts_addr, sts_syndrome}), 64'd0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    // R12: no mask armed after reset, so a first write reads back clean
    op(1, 40, 64'h0123_4567_89ab_cdef);
    op(0, 40, '0);
    idle(1);

    // R2: clean traffic, several patterns, back to back
    op(1, 0, 64'h0);
    op(1, 1, '1);
    op(1, 2, 64'haaaa_aaaa_aaaa_aaaa);
    op(1, 3, 64'h5555_5555_5555_5555);
    for (int a = 4; a < 8; a++) op(1, a, {$urandom, $urandom});
    for (int a = 0; a < 8; a++) op(0, a, '0);
    idle(2);

    // R1 R3 R5 R9: single faults at check, parity and data positions
    for (int k = 0; k < 12; k++) begin
      single_fault(8 + k, pos_list[k]);
      if (k % 4 == 3) clear(3'b111);
    end

    // R4 R1: double faults, data withheld, fault remains
    clear(3'b111);
    load_inj((KW'(1) << 5) | (KW'(1) << 9));
    op(1, 30, 64'hdead_beef_0000_1111);
    op(0, 30, '0);
    op(0, 30, '0);
    idle(1);
    load_inj((KW'(1) << 0) | (KW'(1) << 70));
    op(1, 31, 64'h1);
    op(0, 31, '0);
    idle(1);
    clear(3'b010); // R11: fatal flag only
    idle(1);

    // R6: load coinciding with a write; write takes old mask, new stays armed
    load_inj(KW'(1) << 10);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(33); req_wdata = 64'hface;
    inj_load = 1'b1; inj_mask = KW'(1) << 20;
    @(negedge clk); #1;
    inj_load = 1'b0; req_valid = 1'b0;
    op(1, 34, 64'hcafe);
    op(1, 35, 64'hbead); // no mask left
    op(0, 33, '0);
    op(0, 34, '0);
    op(0, 35, '0);
    idle(1);

    // R5: read stalled behind a write-back
    clear(3'b111);
    load_inj(KW'(1) << 45);
    op(1, 36, 64'h7777_0000_7777_0000);
    op(1, 37, 64'h0000_8888_0000_8888);
    op(0, 36, '0);
    op(0, 37, '0);
    op(0, 36, '0);
    idle(1);

    // R11: clear landing in the same cycle as a corrected event
    load_inj(KW'(1) << 12);
    op(1, 38, 64'h99);
    op(0, 38, '0);
    @(negedge clk); #1;
    req_valid = 1'b0; sts_clr = 3'b101;
    @(negedge clk); #1;
    sts_clr = '0;
    idle(1);

    // R10: saturation of the repaired count
    clear(3'b111);
    for (int k = 0; k < 20; k++) single_fault(5, 7);
    idle(2);

    done = 1'b1;
    finish_run();
  end
endmodule